// File: doc/BRIEF.md
# Code-Fetch Bus Monitor Port

This block lets an outside observer watch every program-memory fetch of an embedded microcontroller. While a monitor mode is on, it takes over the keyboard matrix scan pins. Eight of them show the upper half of the fetch address. Eight more form a shared bus that shows the lower address byte and then the fetched code byte. A strobe pin tells which of the two the shared bus holds, and a further pin forwards the core clock. When the mode is off, the scan pins go back to their normal matrix role.

Each accepted fetch takes two core clock cycles on the port: an address phase and then a data phase. When no fetch is waiting, the last address is held with the strobe low. When the mode is switched off while the program request input is high and the external-access input is low, a core reset pulse of fixed length is produced.

Top module: `fetch_mon_port`

## Requirements
- R1: With the mode on, scan-out pin i (i = 0..7) carries fetch address bit 15-i. These eight pins keep the same value through the address phase and the data phase of a fetch.
- R2: The shared bus is mapped with bus bit 7-j on scan-out pin 8+j (j = 0..3) and bus bit 3-j on scan-in pin j (j = 0..3). It carries address bits 7..0 in the address phase and the code byte in the data phase.
- R3: The strobe on scan-in pin 5 is 0 during the address phase and 1 during the data phase.
- R4: A fetch is accepted at a rising edge where `fetch_valid` and `fetch_ready` are both high. Its address phase is visible after that edge and its data phase after the next edge. `fetch_ready` is low during the address phase and high otherwise while the mode is on, so back-to-back fetches fill consecutive cycle pairs.
- R5: When no fetch is accepted after a data phase, the port shows the last accepted address (high pins and shared bus) with the strobe at 0 until the next fetch.
- R6: With the mode on, scan-in pin 4 carries the core clock unchanged, and all six scan-in pin output enables are 1.
- R7: With the mode off, `kso_pin` equals `kso_kbd`, the scan-in output enables are 0, `ksi_to_kbd` equals `ksi_pin_i`, and `fetch_ready` is 0. With the mode on, `ksi_to_kbd` is all ones.
- R8: If `mon_en` is seen low at a rising edge after being high at the previous edge, and at that edge `pgm_req` is 1 and `ext_access` is 0, then `core_rst` is 1 for exactly 4 cycles, starting right after that edge.
- R9: A mode exit with any other `pgm_req`/`ext_access` combination produces no `core_rst` pulse.
- R10: After the synchronous reset, `core_rst` is 0. Turning the mode on with no fetch shows address 0, bus 0 and strobe 0.
- R11: Leaving the mode during the address phase abandons the fetch. On re-entry the port shows the abandoned address with the strobe at 0, and `fetch_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitor mode enable |
| pgm_req | input | 1 | Program request pin level, checked on mode exit |
| ext_access | input | 1 | External-access pin level, checked on mode exit |
| fetch_valid | input | 1 | A fetch is offered |
| fetch_addr | input | 16 | Fetch address |
| fetch_code | input | 8 | Fetched code byte |
| fetch_ready | output | 1 | Port can accept a fetch this cycle |
| kso_kbd | input | 12 | Scan-out values from the keyboard matrix logic |
| ksi_pin_i | input | 6 | Levels read from the scan-in pins |
| kso_pin | output | 12 | Scan-out pin values |
| ksi_pin_o | output | 6 | Scan-in pin output values |
| ksi_pin_oe | output | 6 | Scan-in pin output enables |
| ksi_to_kbd | output | 6 | Scan-in levels delivered to the matrix logic |
| core_rst | output | 1 | Core reset pulse on qualified mode exit |

## Verification
A phase register stuck in the wrong state shows up one cycle after acceptance, either as a strobe that does not rise or as `fetch_ready` staying high during the address phase. A stale byte register shows up on the shared bus in the data phase or in the following idle cycle. A wrong pulse counter or a wrong edge detector shows up as a `core_rst` that is missing, one cycle off, or the wrong length within five cycles of the exit. A pin-order error corrupts the very first monitored cycle. All of these are compared against a pin-level image built separately for every cycle.

// File: rtl/fmp_pkg.sv
package fmp_pkg;
    localparam int FMP_ADDR_W     = 16;
    localparam int FMP_DATA_W     = 8;
    localparam int FMP_RST_CYCLES = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/fmp_fetch_seq.sv
module fmp_fetch_seq
    import fmp_pkg::*;
#(
    parameter int ADDR_W = FMP_ADDR_W,
    parameter int DATA_W = FMP_DATA_W,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_code,
    output logic              fetch_ready,
    output logic [HI_W-1:0]   hi_q,
    output logic [DATA_W-1:0] bus_q,
    output logic              stb_q
);
    phase_t            ph;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] code_q;
    logic              accept;

    assign fetch_ready = en && (ph != PH_ADDR);
    assign accept      = fetch_valid && fetch_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            hi_q   <= '0;
            lo_q   <= '0;
            code_q <= '0;
            bus_q  <= '0;
            stb_q  <= 1'b0;
        end else if (!en) begin
            ph    <= PH_IDLE;
            bus_q <= lo_q;
            stb_q <= 1'b0;
        end else if (accept) begin
            ph     <= PH_ADDR;
            hi_q   <= fetch_addr[ADDR_W-1:DATA_W];
            lo_q   <= fetch_addr[DATA_W-1:0];
            bus_q  <= fetch_addr[DATA_W-1:0];
            code_q <= fetch_code;
            stb_q  <= 1'b0;
        end else if (ph == PH_ADDR) begin
            ph    <= PH_DATA;
            bus_q <= code_q;
            stb_q <= 1'b1;
        end else begin
            ph    <= PH_IDLE;
            bus_q <= lo_q;
            stb_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fmp_exit_reset.sv
module fmp_exit_reset #(
    parameter int RST_CYCLES = 4,
    localparam int CW        = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pgm_req,
    input  logic ext_access,
    output logic core_rst
);
    logic          en_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            cnt  <= '0;
        end else begin
            en_q <= en;
            if (en_q && !en && pgm_req && !ext_access)
                cnt <= CW'(RST_CYCLES);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign core_rst = (cnt != '0);
endmodule

// File: rtl/fmp_pin_mux.sv
module fmp_pin_mux #(
    parameter int HI_W    = 8,
    parameter int DATA_W  = 8,
    localparam int BUS_SO = DATA_W / 2,
    localparam int BUS_SI = DATA_W - BUS_SO,
    localparam int KSO_N  = HI_W + BUS_SO,
    localparam int KSI_N  = BUS_SI + 2
) (
    input  logic              clk,
    input  logic              en,
    input  logic [HI_W-1:0]   hi_q,
    input  logic [DATA_W-1:0] bus_q,
    input  logic              stb_q,
    input  logic [KSO_N-1:0]  kso_kbd,
    input  logic [KSI_N-1:0]  ksi_pin_i,
    output logic [KSO_N-1:0]  kso_pin,
    output logic [KSI_N-1:0]  ksi_pin_o,
    output logic [KSI_N-1:0]  ksi_pin_oe,
    output logic [KSI_N-1:0]  ksi_to_kbd
);
    logic [KSO_N-1:0] mon_kso;
    logic [KSI_N-1:0] mon_ksi;

    for (genvar i = 0; i < HI_W; i++) begin : g_hi
        assign mon_kso[i] = hi_q[HI_W-1-i];
    end
    for (genvar j = 0; j < BUS_SO; j++) begin : g_bus_so
        assign mon_kso[HI_W+j] = bus_q[DATA_W-1-j];
    end
    for (genvar j = 0; j < BUS_SI; j++) begin : g_bus_si
        assign mon_ksi[j] = bus_q[BUS_SI-1-j];
    end
    assign mon_ksi[BUS_SI]   = clk;
    assign mon_ksi[BUS_SI+1] = stb_q;

    always_comb begin
        if (en) begin
            kso_pin    = mon_kso;
            ksi_pin_o  = mon_ksi;
            ksi_pin_oe = '1;
            ksi_to_kbd = '1;
        end else begin
            kso_pin    = kso_kbd;
            ksi_pin_o  = '0;
            ksi_pin_oe = '0;
            ksi_to_kbd = ksi_pin_i;
        end
    end
endmodule

// File: rtl/fetch_mon_port.sv
module fetch_mon_port
    import fmp_pkg::*;
#(
    parameter int ADDR_W     = FMP_ADDR_W,
    parameter int DATA_W     = FMP_DATA_W,
    parameter int RST_CYCLES = FMP_RST_CYCLES,
    localparam int HI_W      = ADDR_W - DATA_W,
    localparam int KSO_N     = HI_W + DATA_W / 2,
    localparam int KSI_N     = DATA_W - DATA_W / 2 + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_en,
    input  logic              pgm_req,
    input  logic              ext_access,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_code,
    output logic              fetch_ready,
    input  logic [KSO_N-1:0]  kso_kbd,
    input  logic [KSI_N-1:0]  ksi_pin_i,
    output logic [KSO_N-1:0]  kso_pin,
    output logic [KSI_N-1:0]  ksi_pin_o,
    output logic [KSI_N-1:0]  ksi_pin_oe,
    output logic [KSI_N-1:0]  ksi_to_kbd,
    output logic              core_rst
);
    logic [HI_W-1:0]   hi_q;
    logic [DATA_W-1:0] bus_q;
    logic              stb_q;

    fmp_fetch_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en          (mon_en),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .fetch_code  (fetch_code),
        .fetch_ready (fetch_ready),
        .hi_q        (hi_q),
        .bus_q       (bus_q),
        .stb_q       (stb_q)
    );

    fmp_exit_reset #(.RST_CYCLES(RST_CYCLES)) u_xrst (
        .clk        (clk),
        .rst        (rst),
        .en         (mon_en),
        .pgm_req    (pgm_req),
        .ext_access (ext_access),
        .core_rst   (core_rst)
    );

    fmp_pin_mux #(.HI_W(HI_W), .DATA_W(DATA_W)) u_mux (
        .clk        (clk),
        .en         (mon_en),
        .hi_q       (hi_q),
        .bus_q      (bus_q),
        .stb_q      (stb_q),
        .kso_kbd    (kso_kbd),
        .ksi_pin_i  (ksi_pin_i),
        .kso_pin    (kso_pin),
        .ksi_pin_o  (ksi_pin_o),
        .ksi_pin_oe (ksi_pin_oe),
        .ksi_to_kbd (ksi_to_kbd)
    );
endmodule

// File: rtl/fmp_checker.sv
module fmp_checker #(
    parameter int HI_W  = 8,
    parameter int KSO_N = 12,
    parameter int KSI_N = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             mon_en,
    input logic             pgm_req,
    input logic             ext_access,
    input logic             fetch_valid,
    input logic             fetch_ready,
    input logic [KSO_N-1:0] kso_pin,
    input logic [KSI_N-1:0] ksi_pin_o,
    input logic             core_rst
);
    logic accept;
    logic exit_qual;
    assign accept    = fetch_valid && fetch_ready;
    assign exit_qual = pgm_req && !ext_access && !mon_en;

    AST_ADDR_PHASE_STB_LOW: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!mon_en || !ksi_pin_o[KSI_N-1])); // R3

    AST_DATA_PHASE_STB_HIGH: assert property (@(posedge clk) disable iff (rst)
        accept ##1 mon_en |=> (!mon_en || ksi_pin_o[KSI_N-1])); // R4

    AST_BUSY_IN_ADDR_PHASE: assert property (@(posedge clk) disable iff (rst)
        accept |=> !fetch_ready); // R4

    AST_HIGH_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mon_en && $past(mon_en) && ksi_pin_o[KSI_N-1]) |-> $stable(kso_pin[HI_W-1:0])); // R1

    AST_EXIT_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        ($past(mon_en) && exit_qual) |=> core_rst); // R8

    AST_NO_SPURIOUS_RST: assert property (@(posedge clk) disable iff (rst)
        (!core_rst && !($past(mon_en) && exit_qual)) |=> !core_rst); // R9
endmodule

bind fetch_mon_port fmp_checker #(.HI_W(HI_W), .KSO_N(KSO_N), .KSI_N(KSI_N)) u_fmp_chk (
    .clk         (clk),
    .rst         (rst),
    .mon_en      (mon_en),
    .pgm_req     (pgm_req),
    .ext_access  (ext_access),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .kso_pin     (kso_pin),
    .ksi_pin_o   (ksi_pin_o),
    .core_rst    (core_rst)
);

// File: tb/fetch_mon_port_bench.sv
`timescale 1ns/1ps
module fetch_mon_port_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        mon_en, pgm_req, ext_access, fetch_valid;
    logic [15:0] fetch_addr;
    logic [7:0]  fetch_code;
    logic        fetch_ready;
    logic [11:0] kso_kbd, kso_pin;
    logic [5:0]  ksi_pin_i, ksi_pin_o, ksi_pin_oe, ksi_to_kbd;
    logic        core_rst;

    int n_chk = 0;
    int n_fail = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  last_hi, last_lo;

    always #5 clk = ~clk;

    fetch_mon_port u_fetch_mon_port (
        .clk(clk), .rst(rst), .mon_en(mon_en), .pgm_req(pgm_req),
        .ext_access(ext_access), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_code(fetch_code),
        .fetch_ready(fetch_ready), .kso_kbd(kso_kbd), .ksi_pin_i(ksi_pin_i),
        .kso_pin(kso_pin), .ksi_pin_o(ksi_pin_o), .ksi_pin_oe(ksi_pin_oe),
        .ksi_to_kbd(ksi_to_kbd), .core_rst(core_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pin image {kso[11:0], strobe, ksi[3:0]} built from the requirement mapping
    function automatic logic [16:0] image(input logic [7:0] hi, input logic [7:0] bus, input logic stb);
        logic [11:0] so;
        logic [3:0]  si;
        for (int i = 0; i < 8; i++) so[i] = hi[7-i];
        for (int j = 0; j < 4; j++) so[8+j] = bus[7-j];
        for (int j = 0; j < 4; j++) si[j] = bus[3-j];
        return {so, stb, si};
    endfunction

    task automatic push(input logic [16:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one queued item per cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [16:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {15'd0, kso_pin, ksi_pin_o[5], ksi_pin_o[3:0]}, {15'd0, e});
        end
    end

    task automatic do_fetch(input logic [15:0] a, input logic [7:0] c);
        @(negedge clk);
        check("R4 ready before fetch", {31'd0, fetch_ready}, 32'd1);
        fetch_valid = 1'b1; fetch_addr = a; fetch_code = c;
        @(posedge clk);
        push(image(a[15:8], a[7:0], 1'b0), "R1 R2 R3 address phase");
        last_hi = a[15:8]; last_lo = a[7:0];
        @(negedge clk);
        fetch_valid = 1'b0;
        check("R4 ready low in address phase", {31'd0, fetch_ready}, 32'd0);
        @(posedge clk);
        push(image(a[15:8], c, 1'b1), "R1 R2 R3 R4 data phase");
    endtask

    task automatic do_idle();
        @(posedge clk);
        push(image(last_hi, last_lo, 1'b0), "R5 idle hold");
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic exit_and_watch(input logic p, input logic x, input logic expect_pulse, input string tag);
        logic [5:0] seen;
        @(negedge clk);
        mon_en = 1'b0; pgm_req = p; ext_access = x;
        check({tag, " before edge"}, {31'd0, core_rst}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seen[k] = core_rst;
        end
        check(tag, {26'd0, seen}, expect_pulse ? 32'h0F : 32'h00);
        pgm_req = 1'b0; ext_access = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; mon_en = 1'b0; pgm_req = 1'b0; ext_access = 1'b0;
        fetch_valid = 1'b0; fetch_addr = '0; fetch_code = '0;
        kso_kbd = 12'hA5C; ksi_pin_i = 6'h2B;
        last_hi = '0; last_lo = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 core_rst after reset", {31'd0, core_rst}, 32'd0);
        check("R7 ready low when off", {31'd0, fetch_ready}, 32'd0);
        check("R7 scan-out pass-through", {20'd0, kso_pin}, {20'd0, kso_kbd});
        check("R7 scan-in oe off", {26'd0, ksi_pin_oe}, 32'd0);
        check("R7 scan-in to matrix", {26'd0, ksi_to_kbd}, 32'h2B);

        mon_en = 1'b1;
        #1;
        check("R10 reset image", {15'd0, kso_pin, ksi_pin_o[5], ksi_pin_o[3:0]},
              {15'd0, image(8'h00, 8'h00, 1'b0)});
        check("R6 scan-in oe on", {26'd0, ksi_pin_oe}, 32'h3F);
        check("R7 matrix sees all ones", {26'd0, ksi_to_kbd}, 32'h3F);
        check("R6 clock pin low phase", {31'd0, ksi_pin_o[4]}, 32'd0);
        @(posedge clk);
        #1;
        check("R6 clock pin high phase", {31'd0, ksi_pin_o[4]}, 32'd1);

        do_fetch(16'h1234, 8'hC7);
        do_fetch(16'hFE01, 8'h5A);
        do_idle();
        do_idle();
        do_fetch(16'h8000, 8'hFF);
        do_fetch(16'h00FF, 8'h00);
        do_idle();
        do_fetch(16'h6A93, 8'h3C);
        drain();

        kso_kbd = 12'h3C3; ksi_pin_i = 6'h15;
        exit_and_watch(1'b1, 1'b0, 1'b1, "R8 qualified exit pulse");
        check("R7 pass-through after exit", {20'd0, kso_pin}, 32'h3C3);
        check("R7 scan-in after exit", {26'd0, ksi_to_kbd}, 32'h15);

        @(negedge clk); mon_en = 1'b1;
        repeat (2) @(negedge clk);
        exit_and_watch(1'b1, 1'b1, 1'b0, "R9 exit with ext_access high");
        @(negedge clk); mon_en = 1'b1;
        repeat (2) @(negedge clk);
        exit_and_watch(1'b0, 1'b0, 1'b0, "R9 exit with pgm_req low");

        // R11: leave during the address phase
        @(negedge clk); mon_en = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 16'hBEEF; fetch_code = 8'h42;
        @(negedge clk);
        fetch_valid = 1'b0; mon_en = 1'b0;
        repeat (2) @(negedge clk);
        mon_en = 1'b1;
        #1;
        check("R11 re-entry image", {15'd0, kso_pin, ksi_pin_o[5], ksi_pin_o[3:0]},
              {15'd0, image(8'hBE, 8'hEF, 1'b0)});
        check("R11 ready on re-entry", {31'd0, fetch_ready}, 32'd1);
        @(negedge clk);
        check("R11 strobe stays low", {31'd0, ksi_pin_o[5]}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule